// File: doc/BRIEF.md
# Key Input Edge Interrupt Controller

This block watches a small port of key input pins and turns qualifying transitions into latched per-pin flags and one shared interrupt request. Each pin has its own enable bit and its own edge-select bit; a pin that is enabled and makes its selected transition sets its flag. The flag then holds its value whatever the pin does next, so software can find out later which key caused the request.

Software reaches the block over a simple register bus. There are four registers: pin enables, edge selects, the flag register and the request bit. A read of the flag register clears exactly the flags it returned. A flag set in the same cycle as that read survives it. A write of any value to the flag register clears every flag. The request bit stays set until software writes 0 to it.

The trigger logic qualifies each synchronized pin level with its enable and edge select and reacts to that qualified level rising. As a result, changing an enable or an edge select while a pin already rests at its active level creates an event. Software is expected to flush such events after it reconfigures the block.

Top module: `kie_ctrl`

## Requirements
- R1: Every pin passes through a two-flop synchronizer. A qualifying pin change made before clock edge k shows in the flag register and on `irq_o` right after edge k+2.
- R2: An edge-select bit of 1 makes its pin trigger on a rising edge and 0 on a falling edge. The opposite edge on that pin sets no flag.
- R3: A pin whose enable bit is 0 sets no flag and raises no request, whatever it does.
- R4: A set flag stays 1 when its pin returns to its previous level. Only a flag read or a flag write clears it.
- R5: A read at address 2 returns the flags on `bus_rdata` one cycle later and clears exactly the bits it returned. A flag set in the same cycle as the read stays 1.
- R6: A write of any data value to address 2 clears all flags.
- R7: `irq_o` is set whenever any flag is set. It is cleared only by writing a value with bit 0 = 0 to address 3. A set in the same cycle as that clear wins, and writing bit 0 = 1 has no effect.
- R8: After a synchronous reset, the enable, edge-select and flag registers, the request bit and `bus_rdata` are all 0.
- R9: Enabling a pin that already rests at its active level, or flipping its edge select so that its current level becomes active, sets that pin's flag and the request bit.
- R10: Address 0 holds the enables and address 1 holds the edge selects, with bit i belonging to pin i; both can be written and read back. A read at address 3 returns the request bit in bit 0 and zeros above it. Read data is registered and appears one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_i | input | NPINS | Asynchronous key input pins |
| bus_addr | input | AW | Register address (0 enable, 1 edge select, 2 flags, 3 request) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| irq_o | output | 1 | Sticky interrupt request |

## Verification
The assertions check on every cycle that:
- a flag never drops without a flag read or write;
- a flag write leaves only flags set in that same cycle;
- read data equals the flags sampled when the read was taken;
- the request stays set until it is cleared;
- a block with no enables never raises a new request.

The cycle-level reference model in the bench is needed for the rest: the two-cycle synchronizer latency, the polarity of each edge select, the spurious events after reconfiguration, and the read-versus-set and clear-versus-set races. Each of these is reached only by a timed pin and bus sequence.

// File: rtl/kie_pkg.sv
package kie_pkg;
  localparam int ADDR_EN  = 0;
  localparam int ADDR_SEL = 1;
  localparam int ADDR_EVT = 2;
  localparam int ADDR_REQ = 3;
  localparam int SYNC_DEPTH = 2;
endpackage

// File: rtl/kie_sync.sv
module kie_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/kie_edge.sv
module kie_edge #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] level_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] sel_i,
  output logic [N-1:0] hit_o
);
  logic [N-1:0] active;
  logic [N-1:0] active_q;

  generate
    for (genvar i = 0; i < N; i++) begin : g_pin
      always_comb begin
        active[i] = en_i[i] & (sel_i[i] ? level_i[i] : ~level_i[i]);
        hit_o[i]  = active[i] & ~active_q[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) active_q <= '0;
    else     active_q <= active;
  end
endmodule

// File: rtl/kie_regs.sv
module kie_regs
  import kie_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  input  logic [N-1:0]  hit_i,
  output logic [DW-1:0] bus_rdata,
  output logic [N-1:0]  en_o,
  output logic [N-1:0]  sel_o,
  output logic [N-1:0]  evt_o,
  output logic          req_o
);
  logic wr_en, wr_sel, wr_evt, wr_req, rd_evt;
  logic [N-1:0] evt_keep;
  logic [DW-1:0] rd_mux;

  always_comb begin
    wr_en  = bus_wr && (bus_addr == AW'(ADDR_EN));
    wr_sel = bus_wr && (bus_addr == AW'(ADDR_SEL));
    wr_evt = bus_wr && (bus_addr == AW'(ADDR_EVT));
    wr_req = bus_wr && (bus_addr == AW'(ADDR_REQ));
    rd_evt = bus_rd && (bus_addr == AW'(ADDR_EVT));
    evt_keep = evt_o;
    if (wr_evt) evt_keep = '0;
    else if (rd_evt) evt_keep = evt_o & ~evt_o;
    rd_mux = '0;
    case (bus_addr)
      AW'(ADDR_EN):  rd_mux = DW'(en_o);
      AW'(ADDR_SEL): rd_mux = DW'(sel_o);
      AW'(ADDR_EVT): rd_mux = DW'(evt_o);
      AW'(ADDR_REQ): rd_mux = DW'(req_o);
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o      <= '0;
      sel_o     <= '0;
      evt_o     <= '0;
      req_o     <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (wr_en)  en_o  <= bus_wdata[N-1:0];
      if (wr_sel) sel_o <= bus_wdata[N-1:0];
      evt_o <= evt_keep | hit_i;
      req_o <= (req_o & ~(wr_req & ~bus_wdata[0])) | (|hit_i);
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/kie_ctrl.sv
module kie_ctrl
  import kie_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int DW    = 8,
  parameter int AW    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] key_i,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             irq_o
);
  logic [NPINS-1:0] key_s, en_q, sel_q, evt_q, hit;

  kie_sync #(.W(NPINS), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst(rst), .d_i(key_i), .q_o(key_s)
  );

  kie_edge #(.N(NPINS)) u_edge (
    .clk(clk), .rst(rst), .level_i(key_s), .en_i(en_q), .sel_i(sel_q),
    .hit_o(hit)
  );

  kie_regs #(.N(NPINS), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .hit_i(hit),
    .bus_rdata(bus_rdata), .en_o(en_q), .sel_o(sel_q), .evt_o(evt_q),
    .req_o(irq_o)
  );
endmodule

// File: rtl/kie_ctrl_chk.sv
module kie_ctrl_chk #(
  parameter int NPINS = 8,
  parameter int DW    = 8,
  parameter int AW    = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [DW-1:0]    bus_wdata,
  input logic [DW-1:0]    bus_rdata,
  input logic             irq_o,
  input logic [NPINS-1:0] en_q,
  input logic [NPINS-1:0] evt_q,
  input logic [NPINS-1:0] hit
);
  logic evt_rd, evt_wr, req_clr;
  assign evt_rd  = bus_rd && (bus_addr == AW'(2));
  assign evt_wr  = bus_wr && (bus_addr == AW'(2));
  assign req_clr = bus_wr && (bus_addr == AW'(3)) && !bus_wdata[0];

  AST_EVT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!evt_rd && !evt_wr) |=> ((evt_q & $past(evt_q)) == $past(evt_q))); // R4
  AST_EVT_WR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    evt_wr |=> ((evt_q & ~$past(hit)) == '0)); // R6
  AST_EVT_RD_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (evt_rd && !evt_wr) |=> ((evt_q & $past(evt_q) & ~$past(hit)) == '0)); // R5
  AST_EVT_RD_DATA: assert property (@(posedge clk) disable iff (rst)
    evt_rd |=> (bus_rdata == DW'($past(evt_q)))); // R5
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !req_clr) |=> irq_o); // R7
  AST_NEW_EVT_REQ: assert property (@(posedge clk) disable iff (rst)
    ((evt_q & ~$past(evt_q)) != '0) |-> irq_o); // R7
  AST_NO_EN_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (!irq_o && en_q == '0) |=> !irq_o); // R3
endmodule

bind kie_ctrl kie_ctrl_chk #(.NPINS(NPINS), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq_o(irq_o), .en_q(en_q), .evt_q(evt_q), .hit(hit)
);

// File: tb/test_kie_ctrl.sv
`timescale 1ns/1ps
module test_kie_ctrl;
  logic clk = 0;
  logic rst = 1;
  logic [7:0] key = '0;
  logic [1:0] addr = '0;
  logic wr = 0, rd = 0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  kie_ctrl #(.NPINS(8), .DW(8), .AW(2)) i_kie_ctrl (
    .clk(clk), .rst(rst), .key_i(key), .bus_addr(addr), .bus_wr(wr),
    .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  // behavioural reference
  bit [7:0] m_en, m_sel, m_evt, m_rdata, m_lastact;
  bit m_irq;
  bit [7:0] pinq[$];

  always @(posedge clk) begin
    bit [7:0] lev, act, hits;
    if (rst) begin
      m_en = 0; m_sel = 0; m_evt = 0; m_rdata = 0; m_lastact = 0; m_irq = 0;
      pinq.delete();
    end else begin
      lev  = (pinq.size() == 2) ? pinq[0] : 8'h00;
      act  = m_en & ((m_sel & lev) | (~m_sel & ~lev));
      hits = act & ~m_lastact;
      m_lastact = act;
      if (rd) begin
        case (addr)
          2'd0: m_rdata = m_en;
          2'd1: m_rdata = m_sel;
          2'd2: m_rdata = m_evt;
          default: m_rdata = {7'd0, m_irq};
        endcase
      end
      if ((wr || rd) && addr == 2'd2) m_evt = 0;
      m_evt = m_evt | hits;
      if (wr && addr == 2'd3 && !wdata[0]) m_irq = 0;
      if (hits != 0) m_irq = 1;
      if (wr && addr == 2'd0) m_en = wdata;
      if (wr && addr == 2'd1) m_sel = wdata;
      pinq.push_back(key);
      if (pinq.size() > 2) void'(pinq.pop_front());
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(irq === m_irq, "R1 R7 per-cycle irq", irq, m_irq);
      check(rdata === m_rdata, "R1 R5 per-cycle rdata", rdata, m_rdata);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwrite(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic bread(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd = 1;
    @(negedge clk);
    rd = 0; d = rdata;
  endtask

  initial begin
    logic [7:0] v;
    idle(3);
    rst = 0;
    idle(1);
    check(irq === 0, "R8 irq after reset", irq, 0);
    for (int a = 0; a < 4; a++) begin
      bread(a[1:0], v);
      check(v === 8'h00, "R8 register after reset", v, 0);
    end
    // enabling pins resting low with falling select
    bwrite(2'd0, 8'h0F);
    bread(2'd0, v);  check(v === 8'h0F, "R10 enable readback", v, 8'h0F);
    idle(4);
    bread(2'd2, v);  check(v === 8'h0F, "R9 spurious on enable", v, 8'h0F);
    check(irq === 1, "R9 irq on enable", irq, 1);
    bwrite(2'd0, 8'h0F);
    bwrite(2'd2, 8'h5A);
    bread(2'd2, v);  check(v === 8'h00, "R6 write clears flags", v, 0);
    bwrite(2'd3, 8'h00);
    check(irq === 0, "R7 irq cleared", irq, 0);
    bwrite(2'd1, 8'h0F);
    bread(2'd1, v);  check(v === 8'h0F, "R10 select readback", v, 8'h0F);
    idle(4);
    bread(2'd2, v);  check(v === 8'h00, "R2 no event on leaving active", v, 0);
    // rising edge on pin 1
    key[1] = 1; idle(4);
    bread(2'd2, v);  check(v === 8'h02, "R2 rising edge flag", v, 8'h02);
    check(irq === 1, "R7 irq set", irq, 1);
    bread(2'd2, v);  check(v === 8'h00, "R5 read clears", v, 0);
    // sticky flag, opposite edges ignored
    key[2] = 1; idle(4);
    key[2] = 0; key[1] = 0; idle(4);
    bread(2'd2, v);  check(v === 8'h04, "R4 R2 sticky flag, fall ignored", v, 8'h04);
    bwrite(2'd3, 8'h00);
    // disabled pin
    key[5] = 1; idle(4); key[5] = 0; idle(4);
    bread(2'd2, v);  check(v === 8'h00, "R3 disabled pin", v, 0);
    check(irq === 0, "R3 no irq from disabled pin", irq, 0);
    // select flip makes pin 0 active
    bwrite(2'd1, 8'h0E); idle(4);
    bread(2'd2, v);  check(v === 8'h01, "R9 spurious on select flip", v, 8'h01);
    bwrite(2'd2, 8'h00); bwrite(2'd3, 8'h00);
    key[0] = 1; idle(4); key[0] = 0; idle(4);
    bread(2'd2, v);  check(v === 8'h01, "R2 falling edge flag", v, 8'h01);
    bwrite(2'd2, 8'hFF); bwrite(2'd3, 8'h00);
    // read racing a new set
    key[3] = 1; idle(2);
    bread(2'd2, v);  check(v === 8'h00, "R5 R1 read before set", v, 0);
    bread(2'd2, v);  check(v === 8'h08, "R5 set during read kept", v, 8'h08);
    // clear racing a new set
    key[2] = 1; idle(2);
    bwrite(2'd3, 8'h00);
    check(irq === 1, "R7 set wins over clear", irq, 1);
    bwrite(2'd3, 8'h00);
    check(irq === 0, "R7 clear", irq, 0);
    bwrite(2'd3, 8'h01);
    check(irq === 0, "R7 write one ignored", irq, 0);
    bread(2'd3, v);  check(v === 8'h00, "R10 request register", v, 0);
    bread(2'd2, v);  check(v === 8'h04, "R5 flag from race", v, 8'h04);
    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule